// File: doc/BRIEF.md
# Per-line edge-detect interrupt controller

This block monitors a bank of already-filtered digital input lines and reports level transitions to software. Each line has its own enable bit for upward transitions and another for downward transitions. Two global polarity switches sit on top of those masks. A transition that passes both its per-line bit and its global switch sets a sticky edge flag. A further qualifying transition that arrives while the flag is still set raises a sticky overflow flag.

Software sees byte-wide registers on a simple synchronous write port, with an address-selected combinational read. The registers are the two transition masks, a control byte, a status byte and a write-one-to-clear command byte. The control byte gates the edge and overflow flags into a summary status bit, and a master switch gates that summary onto a single interrupt line. The usual arming sequence is to clear both flags and then write the control byte with the master, edge, upward and downward enables all set. Writing zero to the control byte silences the interrupt line.

Top module: `edge_irq_ctrl`

## Requirements
- R1: Register map (6-bit byte address). Upward mask: bytes 0x18, 0x19, 0x1A. Downward mask: bytes 0x20, 0x21, 0x22. Line 8k+b sits in byte k at bit b of each mask. Control is 0x15, and bits 7:5 of it read as 0. Status is 0x14. The clear command is 0x07. Mask and control bytes read back what was written. The clear address, unmapped addresses and status bits 7:3 read as 0, and writes to the status byte are ignored.
- R2: An upward transition on line n, seen between two consecutive clock samples, sets the edge flag (status bit 0) on that clock edge. This happens only if upward-mask bit n and control bit 3 (global upward enable) are both 1.
- R3: A downward transition on line n sets the edge flag on that clock edge. This happens only if downward-mask bit n and control bit 4 (global downward enable) are both 1.
- R4: A transition on a line whose mask bit for that direction is 0 leaves the status byte unchanged.
- R5: A qualifying transition while the edge flag is already 1 sets the overflow flag (status bit 1). Both flags stay set until cleared.
- R6: Writing the clear byte with bit 3 set clears the edge flag, and with bit 2 set clears the overflow flag. The two clears are independent, and the other bits of the clear byte have no effect.
- R7: If an edge clear and a qualifying transition fall in the same cycle, the edge flag stays 1. Because the flag was already 1, the overflow flag is also set.
- R8: Status bit 2 (summary) equals (edge flag AND control bit 0) OR (overflow flag AND control bit 1). It does not depend on control bit 2.
- R9: irq_o equals status bit 2 AND control bit 2 (master enable). A control value of 0x00 holds irq_o at 0.
- R10: After reset, all masks, the control byte and both flags are 0, and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lines_i | input | 24 | Filtered input lines, synchronous to clk_i |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Byte address for read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt request, level |

## Verification
A flag stuck or wrongly set shows on the status byte and on irq_o one clock after the transition that should, or should not, have changed it. The bench therefore reads status right after every transition it drives. A mask bit steering the wrong line shows up in the per-line sweep as an edge flag on a neighbouring line's transition, or as a missing flag on the line's own transition. A wrong gate in the summary or master path shows only under partial control values, so irq_o is compared against the summary bit under several of them.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam int unsigned AW = 6;

  localparam logic [AW-1:0] ADDR_CLR  = 6'h07;
  localparam logic [AW-1:0] ADDR_STAT = 6'h14;
  localparam logic [AW-1:0] ADDR_CTRL = 6'h15;
  localparam logic [AW-1:0] ADDR_RISE = 6'h18;
  localparam logic [AW-1:0] ADDR_FALL = 6'h20;

  localparam int unsigned CLR_EDGE_BIT = 3;
  localparam int unsigned CLR_OVF_BIT  = 2;

  // packed order matches control byte bit positions 4..0
  typedef struct packed {
    logic fall_en;
    logic rise_en;
    logic master_en;
    logic ovf_ie;
    logic edge_ie;
  } ctrl_t;

  typedef struct packed {
    logic master;
    logic ovf;
    logic edge_st;
  } stat_t;
endpackage

// File: rtl/edge_irq_regs.sv
module edge_irq_regs
  import edge_irq_pkg::*;
#(
  parameter int unsigned N_LINES = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [7:0]         wdata_i,
  input  stat_t              stat_i,
  output logic [N_LINES-1:0] rise_mask_o,
  output logic [N_LINES-1:0] fall_mask_o,
  output ctrl_t              ctrl_o,
  output logic               clr_edge_o,
  output logic               clr_ovf_o,
  output logic [7:0]         rdata_o
);
  localparam int unsigned NB = (N_LINES + 7) / 8;
  localparam int unsigned NW = NB * 8;
  localparam logic [NW-1:0] VALID = NW'((64'd1 << N_LINES) - 64'd1);

  logic [NW-1:0] rise_q, fall_q;
  ctrl_t         ctrl_q;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic hit_rise, hit_fall;
    assign hit_rise = we_i && (addr_i == ADDR_RISE + AW'(b));
    assign hit_fall = we_i && (addr_i == ADDR_FALL + AW'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rise_q[b*8 +: 8] <= '0;
        fall_q[b*8 +: 8] <= '0;
      end else begin
        if (hit_rise) rise_q[b*8 +: 8] <= wdata_i & VALID[b*8 +: 8];
        if (hit_fall) fall_q[b*8 +: 8] <= wdata_i & VALID[b*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ctrl_q <= '0;
    else if (we_i && addr_i == ADDR_CTRL) ctrl_q <= ctrl_t'(wdata_i[$bits(ctrl_t)-1:0]);
  end

  assign clr_edge_o  = we_i && (addr_i == ADDR_CLR) && wdata_i[CLR_EDGE_BIT];
  assign clr_ovf_o   = we_i && (addr_i == ADDR_CLR) && wdata_i[CLR_OVF_BIT];
  assign rise_mask_o = rise_q[N_LINES-1:0];
  assign fall_mask_o = fall_q[N_LINES-1:0];
  assign ctrl_o      = ctrl_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_STAT) rdata_o = 8'(stat_i);
    if (addr_i == ADDR_CTRL) rdata_o = 8'(ctrl_q);
    for (int b = 0; b < NB; b++) begin
      if (addr_i == ADDR_RISE + AW'(b)) rdata_o = rise_q[b*8 +: 8];
      if (addr_i == ADDR_FALL + AW'(b)) rdata_o = fall_q[b*8 +: 8];
    end
  end
endmodule

// File: rtl/edge_irq_detect.sv
module edge_irq_detect #(
  parameter int unsigned N_LINES = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] lines_i,
  input  logic [N_LINES-1:0] rise_mask_i,
  input  logic [N_LINES-1:0] fall_mask_i,
  input  logic               rise_en_i,
  input  logic               fall_en_i,
  output logic               hit_o
);
  logic [N_LINES-1:0] prev_q, rise_ev, fall_ev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lines_i;
  end

  assign rise_ev = lines_i & ~prev_q & rise_mask_i & {N_LINES{rise_en_i}};
  assign fall_ev = ~lines_i & prev_q & fall_mask_i & {N_LINES{fall_en_i}};
  assign hit_o   = |(rise_ev | fall_ev);
endmodule

// File: rtl/edge_irq_status.sv
module edge_irq_status
  import edge_irq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  hit_i,
  input  logic  clr_edge_i,
  input  logic  clr_ovf_i,
  input  ctrl_t ctrl_i,
  output stat_t stat_o,
  output logic  irq_o
);
  logic edge_q, ovf_q, master;

  // a new edge wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (hit_i)           edge_q <= 1'b1;
      else if (clr_edge_i) edge_q <= 1'b0;
      if (hit_i && edge_q) ovf_q <= 1'b1;
      else if (clr_ovf_i)  ovf_q <= 1'b0;
    end
  end

  assign master = (edge_q && ctrl_i.edge_ie) || (ovf_q && ctrl_i.ovf_ie);
  assign stat_o = '{master: master, ovf: ovf_q, edge_st: edge_q};
  assign irq_o  = master && ctrl_i.master_en;
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int unsigned N_LINES = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] lines_i,
  input  logic               we_i,
  input  logic [5:0]         addr_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  output logic               irq_o
);
  logic [N_LINES-1:0] rise_mask, fall_mask;
  ctrl_t              ctrl;
  stat_t              stat;
  logic               clr_edge, clr_ovf, hit;

  edge_irq_regs #(.N_LINES(N_LINES)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .stat_i(stat), .rise_mask_o(rise_mask), .fall_mask_o(fall_mask),
    .ctrl_o(ctrl), .clr_edge_o(clr_edge), .clr_ovf_o(clr_ovf), .rdata_o
  );

  edge_irq_detect #(.N_LINES(N_LINES)) u_detect (
    .clk_i, .rst_ni, .lines_i,
    .rise_mask_i(rise_mask), .fall_mask_i(fall_mask),
    .rise_en_i(ctrl.rise_en), .fall_en_i(ctrl.fall_en), .hit_o(hit)
  );

  edge_irq_status u_status (
    .clk_i, .rst_ni, .hit_i(hit), .clr_edge_i(clr_edge), .clr_ovf_i(clr_ovf),
    .ctrl_i(ctrl), .stat_o(stat), .irq_o
  );
endmodule

// File: rtl/edge_irq_ctrl_chk.sv
module edge_irq_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hit_i,
  input logic       edge_i,
  input logic       ovf_i,
  input logic       clr_edge_i,
  input logic [4:0] ctrl_i,
  input logic       irq_i
);
  AST_EDGE_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(edge_i) |-> $past(hit_i)); // R2
  AST_EDGE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_i && !clr_edge_i |=> edge_i); // R5
  AST_OVF_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_i) |-> $past(hit_i && edge_i)); // R5
  AST_CLEAR_LOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_edge_i && hit_i |=> edge_i); // R7
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (edge_i || ovf_i)); // R8
  AST_CTRL_ZERO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i == 5'd0 |-> !irq_i); // R9
endmodule

bind edge_irq_ctrl edge_irq_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit), .edge_i(stat.edge_st),
  .ovf_i(stat.ovf), .clr_edge_i(clr_edge), .ctrl_i(ctrl), .irq_i(irq_o)
);

// File: tb/edge_irq_ctrl_bench.sv
module edge_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] lines = '0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  edge_irq_ctrl u_edge_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .lines_i(lines), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic wr24(input logic [5:0] base, input logic [23:0] v);
    for (int k = 0; k < 3; k++) wr(base + 6'(k), v[k*8 +: 8]);
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic drive(input logic [23:0] v);
    @(negedge clk); lines = v;
    @(negedge clk);
  endtask

  task automatic status_is(input string req, input int exp);
    logic [7:0] s;
    rd(6'h14, s);
    check(req, int'(s), exp);
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    status_is("R10 status", 0);
    rd(6'h15, d); check("R10 ctrl", d, 0);
    rd(6'h18, d); check("R10 rise", d, 0);
    rd(6'h22, d); check("R10 fall", d, 0);
    check("R10 irq", irq, 0);

    // R1 register map
    wr24(6'h18, 24'h813CA5);
    wr24(6'h20, 24'h5A0F77);
    for (int k = 0; k < 3; k++) begin
      rd(6'h18 + 6'(k), d); check("R1 rise readback", d, (24'h813CA5 >> (8*k)) & 8'hFF);
      rd(6'h20 + 6'(k), d); check("R1 fall readback", d, (24'h5A0F77 >> (8*k)) & 8'hFF);
    end
    wr(6'h15, 8'hE0);
    rd(6'h15, d); check("R1 ctrl upper bits", d, 0);
    rd(6'h07, d); check("R1 clear reads zero", d, 0);
    rd(6'h30, d); check("R1 unmapped", d, 0);
    wr(6'h14, 8'hFF);
    status_is("R1 status write ignored", 0);

    // R2/R3/R4 sweep over every line and direction
    for (int i = 0; i < 24; i++) begin
      for (int dir = 0; dir < 2; dir++) begin
        automatic logic [23:0] bit_i = 24'd1 << i;
        automatic logic [23:0] bit_j = 24'd1 << ((i + 1) % 24);
        drive('0);
        wr(6'h15, 8'h1F);
        wr24(6'h18, dir == 0 ? bit_i : 24'd0);
        wr24(6'h20, dir == 1 ? bit_i : 24'd0);
        wr(6'h07, 8'h0C);
        drive(bit_j); drive('0);
        status_is("R4 neighbour line", 0);
        drive(bit_i);
        status_is(dir == 0 ? "R2 rise on line" : "R4 rise on fall-only line",
                  dir == 0 ? 5 : 0);
        drive('0);
        status_is(dir == 0 ? "R4 fall on rise-only line" : "R3 fall on line", 5);
        check("R9 irq after sweep", irq, 1);
      end
    end

    // R2 global upward switch off
    wr(6'h15, 8'h17);
    wr24(6'h18, 24'h000001); wr24(6'h20, 24'h0);
    wr(6'h07, 8'h0C);
    drive(24'h1);
    status_is("R2 global rise off", 0);
    drive('0);

    // R5 overflow
    wr(6'h15, 8'h1F);
    wr24(6'h18, 24'hFFFFFF);
    wr(6'h07, 8'h0C);
    drive(24'h1);
    status_is("R5 first edge", 5);
    drive(24'h3);
    status_is("R5 second edge", 7);

    // R6 independent clears
    wr(6'h07, 8'h04);
    status_is("R6 clear overflow only", 5);
    wr(6'h07, 8'hF3);
    status_is("R6 other bits", 5);
    wr(6'h07, 8'h08);
    status_is("R6 clear edge", 0);
    check("R6 irq low", irq, 0);

    // R8 summary gating with overflow enable only
    drive('0);
    wr(6'h15, 8'h0E);
    wr(6'h07, 8'h0C);
    drive(24'h4);
    status_is("R8 edge without edge enable", 1);
    check("R8 irq", irq, 0);
    drive(24'hC);
    status_is("R8 overflow enabled", 7);
    check("R9 irq from overflow", irq, 1);

    // R9 master gate
    wr(6'h15, 8'h09);
    status_is("R8 summary ignores master", 7);
    check("R9 master off", irq, 0);
    wr(6'h15, 8'h1F);
    check("R9 master on", irq, 1);
    wr(6'h15, 8'h00);
    check("R9 ctrl zero", irq, 0);

    // R7 clear and new edge in the same cycle
    drive('0);
    wr(6'h15, 8'h1F);
    wr(6'h07, 8'h0C);
    drive(24'h1);
    @(negedge clk); lines = 24'h3; we = 1'b1; addr = 6'h07; wdata = 8'h08;
    @(negedge clk); we = 1'b0;
    status_is("R7 edge wins over clear", 7);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule